// File: doc/BRIEF.md
# Serial TDM Audio Frame Transmitter

This block sits on the controller side of a five-wire serial audio link. It runs on the bit clock that the codec supplies. It divides that clock into frames of 256 bit times and drives the frame sync from that count. In every frame it serializes a 16-bit tag slot and then twelve 20-bit data slots onto the outgoing data line. Both the sync and the data change on the rising edge of the bit clock.

User logic provides two groups of inputs. The first is a command address and command data, qualified by one flag. The second is a left and a right playback sample, qualified by another flag. A one-cycle ready pulse marks the last bit time of each frame. The values present during that cycle are captured on the next rising edge, which starts the new frame. They are then held for the whole frame.

The tag slot states which slots carry valid data. Any slot tagged invalid is sent as all zeros, whatever the inputs hold.

Top module: `audFrameTx`

## Requirements
- R1: A frame lasts 256 bit clocks. `syncOut` is high for the 16 bit times of the tag slot and low for the other 240. Each frame's sync rise follows the previous one by exactly 256 rising edges.
- R2: `frameReady` is high for exactly one bit time per frame, namely the last bit time. The inputs present in that bit time are captured on the next rising edge, and that edge starts the frame that carries them.
- R3: Captured values are held for the whole frame. Input changes after the capture edge have no effect on the frame being sent.
- R4: The tag slot is sent first bit first. Bit 1 is the frame-valid flag, equal to cmdValid OR pcmValid. Bits 2 and 3 equal cmdValid, for slots 1 and 2. Bits 4 and 5 equal pcmValid, for slots 3 and 4. Bits 6 to 13 are 0, for slots 5 to 12. Bits 14 to 16 are reserved and are 0.
- R5: Slot 1 carries `cmdAddr` and slot 2 carries `cmdData`. Each is 20 bits, sent MSB first.
- R6: Slot 3 carries `pcmLeft` and slot 4 carries `pcmRight`. Each is sent as its 16 bits MSB first, followed by four 0 bits.
- R7: A slot whose tag bit is 0 is sent as 20 zero bits, even when its input bus holds ones.
- R8: Slots 5 to 12 are always sent as zeros.
- R9: While `rstN` is low, `syncOut`, `sdoOut` and `frameReady` are all 0. After reset is released, `frameReady` rises on the first rising edge and the first frame starts on the second rising edge. This also holds after a reset applied in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock from the codec; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command address and data are valid for the next frame |
| cmdAddr | input | 20 | Command address word for slot 1 |
| cmdData | input | 20 | Command data word for slot 2 |
| pcmValid | input | 1 | Playback samples are valid for the next frame |
| pcmLeft | input | 16 | Left playback sample for slot 3 |
| pcmRight | input | 16 | Right playback sample for slot 4 |
| frameReady | output | 1 | One-cycle pulse during the last bit time of a frame |
| syncOut | output | 1 | Frame sync, high during the tag slot |
| sdoOut | output | 1 | Serial outgoing data, MSB first |

## Verification
Some properties are checked by the assertions on every cycle:
- the 256-cycle spacing between sync rises;
- the 16-cycle sync high time;
- a ready pulse is always followed by the sync rise, and never by a second ready cycle;
- the held copies of the inputs change only on the capture strobe;
- the data line stays at zero inside any slot marked invalid.

Other properties can only be shown by the bench scenarios, which compare whole frames bit by bit against expected frames built from the inputs:
- the tag bit order;
- the slot placement and left-justification of the samples;
- immunity to input changes in the middle of a frame;
- the restart after a reset in the middle of a frame.

// File: rtl/audFramePkg.sv
package audFramePkg;

  // Strobes from the frame sequencer to the serializer, valid for the coming edge
  typedef struct packed {
    logic loadFrame;  // capture inputs and load the tag slot
    logic loadSlot;   // load the data slot named by slotIdx
  } frameStrobe_t;

endpackage

// File: rtl/audFrameCtl.sv
module audFrameCtl
  import audFramePkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  output frameStrobe_t       strobe,
  output logic [IDX_W-1:0]   slotIdx,
  output logic               syncOut,
  output logic               readyOut
);

  localparam int MAX_W     = (TAG_W > SLOT_W) ? TAG_W : SLOT_W;
  localparam int BIT_W     = $clog2(MAX_W);
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int GAP_W     = $clog2(FRAME_LEN + 2);

  logic [IDX_W-1:0] slotQ, slotD;
  logic [BIT_W-1:0] bitQ, bitD;
  logic             syncQ, readyQ;

  // Next position in the frame: slot 0 is the tag slot
  always_comb begin
    slotD = slotQ;
    bitD  = bitQ + 1'b1;
    if (slotQ == '0) begin
      if (bitQ == BIT_W'(TAG_W - 1)) begin
        slotD = IDX_W'(1);
        bitD  = '0;
      end
    end else if (bitQ == BIT_W'(SLOT_W - 1)) begin
      bitD  = '0;
      slotD = (slotQ == IDX_W'(NUM_SLOTS)) ? '0 : slotQ + 1'b1;
    end
  end

  always_comb begin
    strobe.loadFrame = (slotD == '0) && (bitD == '0);
    strobe.loadSlot  = (slotD != '0) && (bitD == '0);
    slotIdx          = slotD;
  end

  // Reset two bit times before a frame boundary so ready shows first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ  <= IDX_W'(NUM_SLOTS);
      bitQ   <= BIT_W'(SLOT_W - 2);
      syncQ  <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      slotQ  <= slotD;
      bitQ   <= bitD;
      syncQ  <= (slotD == '0);
      readyQ <= (slotD == IDX_W'(NUM_SLOTS)) && (bitD == BIT_W'(SLOT_W - 1));
    end
  end

  assign syncOut  = syncQ;
  assign readyOut = readyQ;

  // Checker state: sync history, high-time and rise-to-rise spacing
  logic             syncPrev, seenRise;
  logic [GAP_W-1:0] gapCnt, highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      seenRise <= 1'b0;
      gapCnt   <= '0;
      highCnt  <= '0;
    end else begin
      syncPrev <= syncQ;
      highCnt  <= syncQ ? highCnt + 1'b1 : '0;
      if (syncQ && !syncPrev) begin
        seenRise <= 1'b1;
        gapCnt   <= GAP_W'(1);
      end else if (gapCnt != '1) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  a_r1_frame_period: assert property (@(posedge clk) disable iff (!rstN)
    (syncQ && !syncPrev && seenRise) |-> (gapCnt == GAP_W'(FRAME_LEN)));

  a_r1_sync_high_time: assert property (@(posedge clk) disable iff (!rstN)
    (!syncQ && syncPrev) |-> (highCnt == GAP_W'(TAG_W)));

  a_r2_ready_leads_sync: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> (syncQ && !readyQ));

endmodule

// File: rtl/audFrameDp.sv
module audFrameDp
  import audFramePkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SAMPLE_W  = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  frameStrobe_t        strobe,
  input  logic [IDX_W-1:0]    slotIdx,
  input  logic                cmdValid,
  input  logic [SLOT_W-1:0]   cmdAddr,
  input  logic [SLOT_W-1:0]   cmdData,
  input  logic                pcmValid,
  input  logic [SAMPLE_W-1:0] pcmLeft,
  input  logic [SAMPLE_W-1:0] pcmRight,
  output logic                sdoOut
);

  localparam int PAD_W   = SLOT_W - SAMPLE_W;
  localparam int TAG_PAD = SLOT_W - TAG_W;

  // Which slot each valid flag governs
  function automatic logic [NUM_SLOTS:1] slotMap(input logic cv, input logic pv);
    logic [NUM_SLOTS:1] m;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      m[k] = (k == 1 || k == 2) ? cv : ((k == 3 || k == 4) ? pv : 1'b0);
    end
    return m;
  endfunction

  logic                heldCmdV, heldPcmV;
  logic [SLOT_W-1:0]   heldAddr, heldData;
  logic [SAMPLE_W-1:0] heldLeft, heldRight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCmdV  <= 1'b0;
      heldPcmV  <= 1'b0;
      heldAddr  <= '0;
      heldData  <= '0;
      heldLeft  <= '0;
      heldRight <= '0;
    end else if (strobe.loadFrame) begin
      heldCmdV  <= cmdValid;
      heldPcmV  <= pcmValid;
      heldAddr  <= cmdAddr;
      heldData  <= cmdData;
      heldLeft  <= pcmLeft;
      heldRight <= pcmRight;
    end
  end

  // Tag word from the live flags, taken on the capture edge
  logic [NUM_SLOTS:1] liveOk, heldOk;
  logic [TAG_W-1:0]   tagWord;

  always_comb begin
    liveOk  = slotMap(cmdValid, pcmValid);
    heldOk  = slotMap(heldCmdV, heldPcmV);
    tagWord = '0;
    tagWord[TAG_W-1] = |liveOk;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      tagWord[TAG_W-1-k] = liveOk[k];
    end
  end

  // Slot contents, zero-stuffed when the slot is tagged invalid
  logic [SLOT_W-1:0] rawWord  [1:NUM_SLOTS];
  logic [SLOT_W-1:0] slotWord [0:NUM_SLOTS];

  assign slotWord[0] = '0;

  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_slot
    if (k == 1) begin : g_addr
      assign rawWord[k] = heldAddr;
    end else if (k == 2) begin : g_data
      assign rawWord[k] = heldData;
    end else if (k == 3) begin : g_left
      assign rawWord[k] = SLOT_W'(heldLeft) << PAD_W;
    end else if (k == 4) begin : g_right
      assign rawWord[k] = SLOT_W'(heldRight) << PAD_W;
    end else begin : g_idle
      assign rawWord[k] = '0;
    end
    assign slotWord[k] = heldOk[k] ? rawWord[k] : '0;
  end

  // Slot-wide shifter, MSB drives the line
  logic [SLOT_W-1:0] outSr;
  logic              curOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr <= '0;
      curOk <= 1'b0;
    end else if (strobe.loadFrame) begin
      outSr <= SLOT_W'(tagWord) << TAG_PAD;
      curOk <= 1'b1;
    end else if (strobe.loadSlot) begin
      outSr <= slotWord[slotIdx];
      curOk <= heldOk[slotIdx];
    end else begin
      outSr <= outSr << 1;
    end
  end

  assign sdoOut = outSr[SLOT_W-1];

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFrame |=> ($stable(heldAddr) && $stable(heldData) && $stable(heldLeft)
                           && $stable(heldRight) && $stable(heldCmdV) && $stable(heldPcmV)));

  a_r7_zero_stuff: assert property (@(posedge clk) disable iff (!rstN)
    !curOk |-> !sdoOut);

endmodule

// File: rtl/audFrameTx.sv
module audFrameTx
  import audFramePkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SAMPLE_W  = 16
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [SLOT_W-1:0]   cmdAddr,
  input  logic [SLOT_W-1:0]   cmdData,
  input  logic                pcmValid,
  input  logic [SAMPLE_W-1:0] pcmLeft,
  input  logic [SAMPLE_W-1:0] pcmRight,
  output logic                frameReady,
  output logic                syncOut,
  output logic                sdoOut
);

  localparam int IDX_W = $clog2(NUM_SLOTS + 1);

  frameStrobe_t     strobe;
  logic [IDX_W-1:0] slotIdx;

  audFrameCtl #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) uCtl (
    .clk(bitClk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .syncOut(syncOut), .readyOut(frameReady)
  );

  audFrameDp #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W)
  ) uDp (
    .clk(bitClk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pcmValid(pcmValid), .pcmLeft(pcmLeft), .pcmRight(pcmRight),
    .sdoOut(sdoOut)
  );

endmodule

// File: tb/tb_audFrameTx.sv
module tb_audFrameTx;

  localparam int FL = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, pcmValid = 1'b0;
  logic [19:0] cmdAddr = '0, cmdData = '0;
  logic [15:0] pcmLeft = '0, pcmRight = '0;
  logic        frameReady, syncOut, sdoOut;

  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  audFrameTx dut (
    .bitClk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .pcmValid(pcmValid), .pcmLeft(pcmLeft),
    .pcmRight(pcmRight), .frameReady(frameReady), .syncOut(syncOut), .sdoOut(sdoOut)
  );

  // {cmdValid, cmdAddr, cmdData, pcmValid, pcmLeft, pcmRight}
  localparam logic [73:0] VEC [6] = '{
    {1'b1, 20'h12345, 20'hABCDE, 1'b1, 16'h8001, 16'h7FFE},
    {1'b0, 20'hFFFFF, 20'hFFFFF, 1'b1, 16'h1234, 16'hFFFF},
    {1'b1, 20'h80000, 20'h00001, 1'b0, 16'hFFFF, 16'hAAAA},
    {1'b0, 20'hFFFFF, 20'hFFFFF, 1'b0, 16'hFFFF, 16'hFFFF},
    {1'b1, 20'h5A5A5, 20'hA5A5A, 1'b1, 16'h0000, 16'hFFFF},
    {1'b1, 20'h00000, 20'h00000, 1'b1, 16'h0000, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] buildFrame(input logic [73:0] v);
    logic cv, pv;
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    cv  = v[73];
    pv  = v[32];
    tag = {cv | pv, cv, cv, pv, pv, 8'h00, 3'b000};
    s1  = cv ? v[72:53] : 20'h0;
    s2  = cv ? v[52:33] : 20'h0;
    s3  = pv ? {v[31:16], 4'h0} : 20'h0;
    s4  = pv ? {v[15:0], 4'h0} : 20'h0;
    return {tag, s1, s2, s3, s4, 160'h0};
  endfunction

  task automatic driveVec(input logic [73:0] v);
    cmdValid = v[73];
    cmdAddr  = v[72:53];
    cmdData  = v[52:33];
    pcmValid = v[32];
    pcmLeft  = v[31:16];
    pcmRight = v[15:0];
  endtask

  task automatic waitReady();
    for (int i = 0; i < 2 * FL && !frameReady; i++) @(negedge clk);
  endtask

  // Called at the negedge where frameReady is high: drive, then record one frame
  task automatic sendAndCheck(input logic [73:0] v, input string name);
    logic [255:0] dBits, sBits, rBits, exp;
    driveVec(v);
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      dBits[FL-1-i] = sdoOut;
      sBits[FL-1-i] = syncOut;
      rBits[FL-1-i] = frameReady;
      if (i == 100) driveVec(~v);   // disturb mid-frame
    end
    exp = buildFrame(v);
    chk(dBits[255:240] === exp[255:240], {"R4 tag ", name}, dBits, exp);
    chk(dBits[239:200] === exp[239:200], {"R5 R7 R3 cmd slots ", name}, dBits, exp);
    chk(dBits[199:160] === exp[199:160], {"R6 R7 R3 pcm slots ", name}, dBits, exp);
    chk(dBits[159:0] === '0, {"R8 idle slots ", name}, dBits, exp);
    chk(sBits === {16'hFFFF, 240'h0}, {"R1 sync shape ", name}, sBits, {16'hFFFF, 240'h0});
    chk(rBits === 256'h1, {"R2 ready pulse ", name}, rBits, 256'h1);
    driveVec(v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk({syncOut, sdoOut, frameReady} === 3'b000, "R9 outputs in reset",
        256'({syncOut, sdoOut, frameReady}), 256'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(frameReady === 1'b1 && syncOut === 1'b0, "R9 R2 ready after first edge",
        256'({frameReady, syncOut}), 256'h2);

    // Table-driven frames, back to back
    foreach (VEC[n]) begin
      waitReady();
      sendAndCheck(VEC[n], $sformatf("vec%0d", n));
    end

    // R9: reset in the middle of a frame, then clean restart
    repeat (37) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk({syncOut, sdoOut, frameReady} === 3'b000, "R9 mid-frame reset",
        256'({syncOut, sdoOut, frameReady}), 256'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(frameReady === 1'b1 && syncOut === 1'b0, "R9 ready after re-release",
        256'({frameReady, syncOut}), 256'h2);
    sendAndCheck(VEC[0], "restart");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule